// File: doc/BRIEF.md
# Nth-Chance Clock Frame Replacement Selector

This block picks which physical frame to give up when a page fault needs room. For every frame it keeps a use flag, a modified flag and a small pass counter. Ordinary memory traffic reports frame references on a reference port. A read sets the frame's use flag. A write also sets its modified flag. A circular hand sweeps the frames only while a fault is being serviced, and it inspects one frame per clock.

A frame that was used since the last pass is spared. Its use flag and its counter are cleared. A frame that was not used has its counter advanced. A clean frame is chosen after one unused pass. A modified frame is chosen after two, and on its first unused pass the block emits a one-cycle writeback hint so the frame can be cleaned in the meantime. A writeback-complete input clears the modified flag.

The fault requester raises a one-cycle request while the block is idle. The block is busy until it pulses done together with the chosen frame and whether that frame still holds modified data. The hand then rests on the frame after the victim.

The controller has three states:
- `ST_IDLE` goes to `ST_SCAN` on a fault request.
- `ST_SCAN` stays in `ST_SCAN` while frames are spared or aged, and goes to `ST_REPORT` when a victim is chosen.
- `ST_REPORT` always goes back to `ST_IDLE`.

Top module: `nth_chance_clock`

## Requirements
- R1: A reference sets the use flag of its frame on the next edge. A reference with the write qualifier also sets that frame's modified flag. A write reference overrides a writeback-complete to the same frame in the same cycle.
- R2: The hand moves only in `ST_SCAN`, by one frame per clock, wrapping from the last frame to frame 0. With a sweep that inspects k frames, done appears k+1 cycles after the cycle in which the request was taken.
- R3: When the hand finds a frame whose use flag is set, that frame's use flag and counter are cleared, it is not chosen, and the hand moves on.
- R4: When the hand finds a clean frame with its use flag clear, the counter is advanced. The frame is chosen once the advanced count is at least 1, and it is reported with the modified indication 0.
- R5: When the hand finds a modified frame with its use flag clear, the counter is advanced. If the advanced count is 1, `wb_req` pulses for one cycle with `wb_frame` equal to that frame, and the hand moves on. If the advanced count reaches 2, the frame is chosen with the modified indication 1.
- R6: A writeback-complete clears the frame's modified flag. A frame that already has one unused pass is then chosen as clean on its next unused inspection.
- R7: When every frame has its use flag set, the sweep still ends. The first lap clears all the flags, and a later lap chooses a frame.
- R8: A reference that arrives in the same cycle as the hand inspects that frame wins. The use flag stays set, and the frame is spared on this lap and on the next one.
- R9: `busy` is high from the cycle after a request is taken through the done cycle. A fault request that arrives while `busy` is high is ignored and starts no second sweep.
- R10: `done` is a one-cycle pulse carrying `victim_frame` and `victim_dirty`. The next sweep starts at the frame after the victim.
- R11: A chosen frame has its use flag, modified flag and counter cleared.
- R12: After reset the hand is at frame 0, all flags and counters are zero, and `busy`, `done` and `wb_req` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_req | input | 1 | Request a victim (taken only when idle) |
| ref_valid | input | 1 | A frame was referenced this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| ref_write | input | 1 | The reference was a write |
| wb_done_valid | input | 1 | The writeback of a frame has finished |
| wb_done_frame | input | IDX_W | Frame whose writeback finished |
| busy | output | 1 | A sweep or its report is in progress |
| done | output | 1 | One-cycle pulse: the victim fields are valid |
| victim_frame | output | IDX_W | Chosen frame |
| victim_dirty | output | 1 | Chosen frame still holds modified data |
| wb_req | output | 1 | One-cycle writeback hint |
| wb_frame | output | IDX_W | Frame named by the writeback hint |

## Verification
The reference port and the hand's inspection can act on the same frame in the same cycle. The bench provokes this by driving a read of the exact frame the hand reaches in the first scan cycle after a fault is taken. It judges the result at the ports: the sweep must skip that frame and choose the next one. A later sweep must then spare that frame once more and raise no writeback hint for it, which shows that the use flag survived. Other cases place a writeback-complete and write references between sweeps, and a second fault request in the middle of a sweep. In each case the scoreboard's ordered lists of hints and victims must match exactly.

// File: rtl/clock_evict_pkg.sv
package clock_evict_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_REPORT
    } sweep_state_e;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_AGE,
        ACT_BUMP,
        ACT_EVICT
    } frame_act_e;

endpackage

// File: rtl/frame_state_table.sv
module frame_state_table
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES    = 8,
    parameter int IDX_W         = 3,
    parameter int CNT_W         = 2,
    parameter int DIRTY_CHANCES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             ref_write,
    input  logic             wb_done_valid,
    input  logic [IDX_W-1:0] wb_done_frame,
    input  frame_act_e       act,
    input  logic [IDX_W-1:0] act_idx,
    output logic             use_at,
    output logic             dirty_at,
    output logic [CNT_W-1:0] cnt_at
);

    logic [NUM_FRAMES-1:0] use_q;
    logic [NUM_FRAMES-1:0] dirty_q;
    logic [CNT_W-1:0]      cnt_q [NUM_FRAMES];

    for (genvar i = 0; i < NUM_FRAMES; i++) begin : g_frame
        logic hit_ref;
        logic hit_act;
        logic hit_wb;

        assign hit_ref = ref_valid && (ref_frame == IDX_W'(i));
        assign hit_act = (act_idx == IDX_W'(i));
        assign hit_wb  = wb_done_valid && (wb_done_frame == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                use_q[i]   <= 1'b0;
                dirty_q[i] <= 1'b0;
                cnt_q[i]   <= '0;
            end else begin
                if (hit_act) begin
                    unique case (act)
                        ACT_AGE: begin
                            use_q[i] <= 1'b0;
                            cnt_q[i] <= '0;
                        end
                        ACT_BUMP: cnt_q[i] <= cnt_q[i] + 1'b1;
                        ACT_EVICT: begin
                            use_q[i]   <= 1'b0;
                            dirty_q[i] <= 1'b0;
                            cnt_q[i]   <= '0;
                        end
                        default: ;
                    endcase
                end
                if (hit_wb) begin
                    dirty_q[i] <= 1'b0;
                end
                // a reference beats any same-cycle ageing or clean-up
                if (hit_ref) begin
                    use_q[i] <= 1'b1;
                    if (ref_write) begin
                        dirty_q[i] <= 1'b1;
                    end
                end
            end
        end

        // R5: a pass counter never passes the modified-frame limit
        p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_q[i] <= CNT_W'(DIRTY_CHANCES));
    end

    assign use_at   = use_q[act_idx];
    assign dirty_at = dirty_q[act_idx];
    assign cnt_at   = cnt_q[act_idx];

    p_ref_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> use_q[$past(ref_frame)]);

    p_wr_dirty_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_write) |=> dirty_q[$past(ref_frame)]);

endmodule

// File: rtl/sweep_fsm.sv
module sweep_fsm
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES    = 8,
    parameter int IDX_W         = 3,
    parameter int CNT_W         = 2,
    parameter int CLEAN_CHANCES = 1,
    parameter int DIRTY_CHANCES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_req,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             use_at,
    input  logic             dirty_at,
    input  logic [CNT_W-1:0] cnt_at,
    output frame_act_e       act,
    output logic [IDX_W-1:0] hand,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_frame,
    output logic             victim_dirty,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_frame
);

    localparam int           SUM_W   = CNT_W + 1;
    localparam logic [SUM_W-1:0] LIM_CLEAN = SUM_W'(CLEAN_CHANCES);
    localparam logic [SUM_W-1:0] LIM_DIRTY = SUM_W'(DIRTY_CHANCES);
    localparam logic [SUM_W-1:0] HINT_AT   = SUM_W'(DIRTY_CHANCES - 1);
    localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(NUM_FRAMES - 1);

    sweep_state_e     state_q, state_n;
    logic [IDX_W-1:0] hand_q, hand_inc;
    logic [SUM_W-1:0] cnt_next, limit;
    logic             seen_use, pick, hint;
    logic [IDX_W-1:0] victim_q, wb_frame_q;
    logic             victim_dirty_q, wb_q;

    assign hand_inc = (hand_q == LAST_IDX) ? '0 : hand_q + 1'b1;
    assign cnt_next = {1'b0, cnt_at} + 1'b1;
    assign limit    = dirty_at ? LIM_DIRTY : LIM_CLEAN;
    assign seen_use = use_at || (ref_valid && (ref_frame == hand_q));

    // decision and next state
    always_comb begin
        state_n = state_q;
        act     = ACT_NONE;
        pick    = 1'b0;
        hint    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fault_req) begin
                    state_n = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (seen_use) begin
                    act = ACT_AGE;
                end else if (cnt_next >= limit) begin
                    act     = ACT_EVICT;
                    pick    = 1'b1;
                    state_n = ST_REPORT;
                end else begin
                    act  = ACT_BUMP;
                    hint = dirty_at && (cnt_next == HINT_AT);
                end
            end
            ST_REPORT: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // hand and registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hand_q         <= '0;
            victim_q       <= '0;
            victim_dirty_q <= 1'b0;
            wb_q           <= 1'b0;
            wb_frame_q     <= '0;
        end else begin
            wb_q <= hint;
            if (hint) begin
                wb_frame_q <= hand_q;
            end
            if (state_q == ST_SCAN) begin
                hand_q <= hand_inc;
            end
            if (pick) begin
                victim_q       <= hand_q;
                victim_dirty_q <= dirty_at;
            end
        end
    end

    assign hand         = hand_q;
    assign busy         = (state_q != ST_IDLE);
    assign done         = (state_q == ST_REPORT);
    assign victim_frame = victim_q;
    assign victim_dirty = victim_dirty_q;
    assign wb_req       = wb_q;
    assign wb_frame     = wb_frame_q;

    p_hand_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> $stable(hand_q));

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_hand_next_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (hand_q == ((victim_q == LAST_IDX) ? '0 : victim_q + 1'b1)));

    p_wb_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> busy);

    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SCAN) |=> (state_q != ST_IDLE));

endmodule

// File: rtl/nth_chance_clock.sv
module nth_chance_clock
    import clock_evict_pkg::*;
#(
    parameter int NUM_FRAMES    = 8,
    parameter int CLEAN_CHANCES = 1,
    parameter int DIRTY_CHANCES = 2,
    parameter int IDX_W         = $clog2(NUM_FRAMES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fault_req,
    input  logic             ref_valid,
    input  logic [IDX_W-1:0] ref_frame,
    input  logic             ref_write,
    input  logic             wb_done_valid,
    input  logic [IDX_W-1:0] wb_done_frame,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] victim_frame,
    output logic             victim_dirty,
    output logic             wb_req,
    output logic [IDX_W-1:0] wb_frame
);

    localparam int CNT_W = $clog2(DIRTY_CHANCES + 1);

    frame_act_e       act;
    logic [IDX_W-1:0] hand;
    logic             use_at, dirty_at;
    logic [CNT_W-1:0] cnt_at;

    frame_state_table #(
        .NUM_FRAMES   (NUM_FRAMES),
        .IDX_W        (IDX_W),
        .CNT_W        (CNT_W),
        .DIRTY_CHANCES(DIRTY_CHANCES)
    ) i_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_valid    (ref_valid),
        .ref_frame    (ref_frame),
        .ref_write    (ref_write),
        .wb_done_valid(wb_done_valid),
        .wb_done_frame(wb_done_frame),
        .act          (act),
        .act_idx      (hand),
        .use_at       (use_at),
        .dirty_at     (dirty_at),
        .cnt_at       (cnt_at)
    );

    sweep_fsm #(
        .NUM_FRAMES   (NUM_FRAMES),
        .IDX_W        (IDX_W),
        .CNT_W        (CNT_W),
        .CLEAN_CHANCES(CLEAN_CHANCES),
        .DIRTY_CHANCES(DIRTY_CHANCES)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .fault_req   (fault_req),
        .ref_valid   (ref_valid),
        .ref_frame   (ref_frame),
        .use_at      (use_at),
        .dirty_at    (dirty_at),
        .cnt_at      (cnt_at),
        .act         (act),
        .hand        (hand),
        .busy        (busy),
        .done        (done),
        .victim_frame(victim_frame),
        .victim_dirty(victim_dirty),
        .wb_req      (wb_req),
        .wb_frame    (wb_frame)
    );

    p_done_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/test_nth_chance_clock.sv
module test_nth_chance_clock;

    localparam int N   = 4;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fault_req = 1'b0;
    logic          ref_valid = 1'b0;
    logic [IW-1:0] ref_frame = '0;
    logic          ref_write = 1'b0;
    logic          wb_done_valid = 1'b0;
    logic [IW-1:0] wb_done_frame = '0;
    logic          busy, done, victim_dirty, wb_req;
    logic [IW-1:0] victim_frame, wb_frame;

    int checks = 0;
    int fails  = 0;
    bit reported = 1'b0;

    int    exp_v[$];
    int    exp_d[$];
    int    exp_n[$];
    string exp_tag[$];
    int    exp_wb[$];
    int    scan_cnt = 0;

    always #2 clk = ~clk;

    nth_chance_clock #(.NUM_FRAMES(N)) i_nth_chance_clock (
        .clk(clk), .rst_n(rst_n), .fault_req(fault_req),
        .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
        .wb_done_valid(wb_done_valid), .wb_done_frame(wb_done_frame),
        .busy(busy), .done(done), .victim_frame(victim_frame),
        .victim_dirty(victim_dirty), .wb_req(wb_req), .wb_frame(wb_frame)
    );

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        if (!reported) begin
            reported = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    endtask

    // monitor: victims and writeback hints against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (wb_req) begin
                if (exp_wb.size() == 0) begin
                    check(1'b0, "R5", "unexpected wb_req frame", int'(wb_frame), -1);
                end else begin
                    int e;
                    e = exp_wb.pop_front();
                    check(int'(wb_frame) == e, "R5", "wb_frame", int'(wb_frame), e);
                end
            end
            if (busy && !done) scan_cnt++;
            if (done) begin
                if (exp_v.size() == 0) begin
                    check(1'b0, "R9", "unexpected done victim", int'(victim_frame), -1);
                end else begin
                    int v, d, n;
                    string t;
                    v = exp_v.pop_front();
                    d = exp_d.pop_front();
                    n = exp_n.pop_front();
                    t = exp_tag.pop_front();
                    check(int'(victim_frame) == v, t, "victim_frame", int'(victim_frame), v);
                    check(int'(victim_dirty) == d, t, "victim_dirty", int'(victim_dirty), d);
                    check(scan_cnt == n, "R2", "scan cycles", scan_cnt, n);
                end
                scan_cnt = 0;
            end
        end
    end

    task automatic touch(int f, bit wr);
        @(negedge clk);
        ref_valid = 1'b1;
        ref_frame = IW'(f);
        ref_write = wr;
        @(negedge clk);
        ref_valid = 1'b0;
        ref_write = 1'b0;
    endtask

    task automatic expect_victim(int v, int d, int n, string tag);
        exp_v.push_back(v);
        exp_d.push_back(d);
        exp_n.push_back(n);
        exp_tag.push_back(tag);
    endtask

    task automatic finish_fault(string tag);
        while (!done) @(negedge clk);
        @(negedge clk);
        check(exp_wb.size() == 0, tag, "missing wb hints", exp_wb.size(), 0);
    endtask

    // issue a fault, optionally with a same-cycle reference to frame same_f
    task automatic run_fault(int v, int d, int n, string tag, int same_f = -1);
        expect_victim(v, d, n, tag);
        @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        if (same_f >= 0) begin
            ref_valid = 1'b1;
            ref_frame = IW'(same_f);
            @(negedge clk);
            ref_valid = 1'b0;
        end
        finish_fault(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "R2", "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(busy == 1'b0, "R12", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R12", "done after reset", int'(done), 0);
        check(wb_req == 1'b0, "R12", "wb_req after reset", int'(wb_req), 0);

        // R4 / R12: all clear, hand at 0
        run_fault(0, 0, 1, "R4");
        // R3: used frames 1 and 2 spared, wrap to 0 afterwards (R10)
        touch(1, 0); touch(2, 0);
        run_fault(3, 0, 3, "R3");
        // R1: write frame 0 sets use and modified; frame 1 then chosen
        touch(0, 1);
        run_fault(1, 0, 2, "R1");
        // R5: modified frame 0 gets a hint on its first unused pass
        touch(2, 0); touch(3, 0);
        exp_wb.push_back(0);
        run_fault(1, 0, 4, "R5");
        // R5: second unused pass chooses it as modified
        touch(1, 0); touch(2, 0); touch(3, 0);
        run_fault(0, 1, 3, "R5");
        // R7: all use flags set, one lap ages them, then a hint and a pick
        touch(1, 1); touch(2, 0); touch(3, 0); touch(0, 0);
        exp_wb.push_back(1);
        run_fault(2, 0, 6, "R7");
        // R6: writeback complete makes frame 1 clean
        @(negedge clk);
        wb_done_valid = 1'b1;
        wb_done_frame = IW'(1);
        @(negedge clk);
        wb_done_valid = 1'b0;
        touch(3, 0); touch(0, 0);
        run_fault(1, 0, 3, "R6");
        // R7 / R9: all modified and used; extra request mid-sweep ignored
        touch(0, 1); touch(1, 1); touch(2, 1); touch(3, 1);
        exp_wb.push_back(2); exp_wb.push_back(3);
        exp_wb.push_back(0); exp_wb.push_back(1);
        expect_victim(2, 1, 9, "R7");
        @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        repeat (3) @(negedge clk);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        finish_fault("R7");
        for (int k = 0; k < 4; k++) begin
            check(busy == 1'b0, "R9", "busy after ignored request", int'(busy), 0);
            @(negedge clk);
        end
        // R8: read of frame 3 in the very cycle the hand inspects it
        run_fault(0, 1, 2, "R8", 3);
        run_fault(1, 1, 1, "R5");
        // R11: frame 2 was chosen modified earlier, now clean and unused
        run_fault(2, 0, 1, "R11");
        // R8: frame 3 still has its use flag, spared again with no hint
        run_fault(0, 0, 2, "R8");

        repeat (3) @(negedge clk);
        check(exp_v.size() == 0, "R10", "pending victims", exp_v.size(), 0);
        summary();
    end

endmodule